// File: doc/BRIEF.md
# Instruction Class Decoder

This block takes 32-bit instruction words from a stream and labels each one with its instruction class: data processing, multiply, long multiply, swap, branch-exchange, the two halfword transfer forms, single transfer, undefined, block transfer, branch, and the three coprocessor forms, plus software interrupt. It does not evaluate the condition field and does not execute anything. It only sorts the word so that a later stage can pick a handler.

The class is chosen from a 12-bit signature. The signature is built from instruction bits 27:20 and 7:4. It is compared against a fixed, ordered list of mask/value entries, and the first entry that matches gives the class. A parameter can switch off single entries. A signature that no enabled entry matches is flagged as unknown.

Words enter on a valid/ready input and leave on a valid/ready output through one register stage. A word is taken on a rising edge where `in_valid` and `in_ready` are both high. Its result shows on `out_valid`/`out_class`/`out_unknown` after that edge. The result is dropped on an edge where `out_valid` and `out_ready` are both high. While the output is stalled, `in_ready` stays low and the held result does not change. A new word can be accepted on the same edge that the held result leaves.

Top module: `instr_class_decoder`

## Requirements
- R1: The signature is `{instr[27:20], instr[7:4]}`: instruction bit 27 is signature bit 11 and instruction bit 4 is signature bit 0. Instruction bits 31:28, 19:8 and 3:0 have no effect on the class.
- R2: Entries are tried in priority order 0 to 14, and the lowest-numbered enabled entry that matches wins. This holds even when a later entry is more specific. With all entries enabled, signatures 0x009, 0x089 and 0x109 therefore decode as halfword-register (5), and 0x0C9 decodes as halfword-immediate (6).
- R3: The upper-space entries, given as priority index: signature/mask → class code, are:
  - 0: F00/F00 → software interrupt (14)
  - 1: E01/F01 → coprocessor register transfer (13)
  - 2: E00/F01 → coprocessor data operation (12)
  - 3: C00/E00 → coprocessor data transfer (11)
- R4: The middle entries are:
  - 4: A00/E00 → branch (10)
  - 5: 800/E00 → block transfer (9)
  - 6: 601/E01 → undefined (8)
  - 7: 400/C00 → single data transfer (7)
- R5: The lower entries are:
  - 8: 049/E49 → halfword immediate offset (6)
  - 9: 009/E49 → halfword register offset (5)
  - 10: 121/FFF → branch-exchange (4)
  - 11: 109/FBF → swap (3)
  - 12: 089/F8F → long multiply (2)
  - 13: 009/FCF → multiply (1)
- R6: Entry 14, 000/C00 → data processing or status transfer (0), is tried last. Any signature with top bits 00 that no earlier entry matches decodes as 0.
- R7: Parameter bit `ENTRY_EN[i]` enables entry i. If no enabled entry matches, `out_unknown` is 1 and `out_class` is 15. Otherwise `out_unknown` is 0.
- R8: A word taken on an edge has its result valid right after that edge. If the result is consumed and no new word is taken, `out_valid` is 0 after the edge.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_class` and `out_unknown` hold their values.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word |
| in_instr | input | 32 | Instruction word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_class | output | 4 | Class code, 15 when unknown |
| out_unknown | output | 1 | No enabled entry matched |

## Verification
The assertions check the stream rules on every cycle:
- the stalled output holds still and blocks the input;
- an accepted word always produces a result one edge later;
- a drained stage goes empty;
- the unknown flag always agrees with the class code 15.

Whether the class code is correct can only be shown by the bench's vectors. These include the priority shadowing of multiply, long multiply and swap by the halfword entries, the bits that must be ignored, and a second instance with entries switched off, which exposes both the shadowed classes and the unknown flag.

// File: rtl/icd_pkg.sv
package icd_pkg;
  localparam int INSTR_W     = 32;
  localparam int SIG_W       = 12;
  localparam int NUM_ENTRIES = 15;
  localparam int CLS_W       = 4;

  typedef enum logic [CLS_W-1:0] {
    CL_DPROC   = 4'd0,
    CL_MUL     = 4'd1,
    CL_MULL    = 4'd2,
    CL_SWAP    = 4'd3,
    CL_BX      = 4'd4,
    CL_HW_REG  = 4'd5,
    CL_HW_IMM  = 4'd6,
    CL_SINGLE  = 4'd7,
    CL_UNDEF   = 4'd8,
    CL_BLOCK   = 4'd9,
    CL_BRANCH  = 4'd10,
    CL_CP_XFER = 4'd11,
    CL_CP_OP   = 4'd12,
    CL_CP_REG  = 4'd13,
    CL_SWI     = 4'd14,
    CL_NONE    = 4'd15
  } cls_e;

  typedef struct packed {
    logic [SIG_W-1:0] mask;
    logic [SIG_W-1:0] value;
    cls_e             cls;
  } entry_t;

  // Priority-ordered match list; lower index wins.
  function automatic entry_t entry_at(input int idx);
    entry_t e;
    case (idx)
      0:  e = '{12'hF00, 12'hF00, CL_SWI};
      1:  e = '{12'hF01, 12'hE01, CL_CP_REG};
      2:  e = '{12'hF01, 12'hE00, CL_CP_OP};
      3:  e = '{12'hE00, 12'hC00, CL_CP_XFER};
      4:  e = '{12'hE00, 12'hA00, CL_BRANCH};
      5:  e = '{12'hE00, 12'h800, CL_BLOCK};
      6:  e = '{12'hE01, 12'h601, CL_UNDEF};
      7:  e = '{12'hC00, 12'h400, CL_SINGLE};
      8:  e = '{12'hE49, 12'h049, CL_HW_IMM};
      9:  e = '{12'hE49, 12'h009, CL_HW_REG};
      10: e = '{12'hFFF, 12'h121, CL_BX};
      11: e = '{12'hFBF, 12'h109, CL_SWAP};
      12: e = '{12'hF8F, 12'h089, CL_MULL};
      13: e = '{12'hFCF, 12'h009, CL_MUL};
      14: e = '{12'hC00, 12'h000, CL_DPROC};
      default: e = '{12'h000, 12'hFFF, CL_NONE};
    endcase
    return e;
  endfunction
endpackage

// File: rtl/icd_sig.sv
module icd_sig
  import icd_pkg::*;
#(
  parameter int HI_LSB = 20,
  parameter int HI_W   = 8,
  parameter int LO_LSB = 4,
  parameter int LO_W   = 4
) (
  input  logic [INSTR_W-1:0]   instr,
  output logic [HI_W+LO_W-1:0] sig
);
  localparam int HI_MSB = HI_LSB + HI_W - 1;
  localparam int LO_MSB = LO_LSB + LO_W - 1;

  assign sig = {instr[HI_MSB:HI_LSB], instr[LO_MSB:LO_LSB]};
endmodule

// File: rtl/icd_match.sv
module icd_match
  import icd_pkg::*;
#(
  parameter logic [NUM_ENTRIES-1:0] ENTRY_EN = '1
) (
  input  logic [SIG_W-1:0] sig,
  output cls_e             cls,
  output logic             none
);
  logic [NUM_ENTRIES-1:0] hit;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    localparam entry_t ENT = entry_at(g);
    if (ENTRY_EN[g]) begin : g_on
      assign hit[g] = ((sig & ENT.mask) == ENT.value);
    end else begin : g_off
      assign hit[g] = 1'b0;
    end
  end

  // Walk from lowest priority upward so the earliest hit overwrites last.
  always_comb begin
    cls = CL_NONE;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) cls = entry_at(i).cls;
    end
  end

  assign none = ~|hit;
endmodule

// File: rtl/icd_stage.sv
module icd_stage
  import icd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  cls_e             in_cls,
  input  logic             in_none,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CLS_W-1:0] out_cls,
  output logic             out_none
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_cls   <= CL_NONE;
      out_none  <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_cls   <= in_cls;
        out_none  <= in_none;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/instr_class_decoder.sv
module instr_class_decoder
  import icd_pkg::*;
#(
  parameter logic [NUM_ENTRIES-1:0] ENTRY_EN = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] in_instr,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [CLS_W-1:0]   out_class,
  output logic               out_unknown
);
  logic [SIG_W-1:0] sig;
  cls_e             cls;
  logic             none;

  icd_sig u_sig (
    .instr (in_instr),
    .sig   (sig)
  );

  icd_match #(.ENTRY_EN(ENTRY_EN)) u_match (
    .sig  (sig),
    .cls  (cls),
    .none (none)
  );

  icd_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_cls    (cls),
    .in_none   (none),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_cls   (out_class),
    .out_none  (out_unknown)
  );
endmodule

// File: rtl/instr_class_decoder_chk.sv
module instr_class_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [3:0] out_class,
  input logic       out_unknown
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_class) && $stable(out_unknown));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  assert_unknown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_unknown == (out_class == 4'hF)));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind instr_class_decoder instr_class_decoder_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_class   (out_class),
  .out_unknown (out_unknown)
);

// File: tb/instr_class_decoder_tb_top.sv
module instr_class_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  // Second instance: software interrupt and both halfword entries off.
  localparam logic [14:0] PART_EN = 15'h7CFE;

  typedef struct packed {
    logic [31:0] instr;
    logic [3:0]  exp_full;
    logic [3:0]  exp_part;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{32'hEF000000, 4'd14, 4'd15}, // R3 swi / R7 unknown in part
    '{32'hEE000010, 4'd13, 4'd13}, // R3 cp reg
    '{32'hEE000000, 4'd12, 4'd12}, // R3 cp op
    '{32'hEC000000, 4'd11, 4'd11}, // R3 cp xfer
    '{32'hEA000000, 4'd10, 4'd10}, // R4 branch
    '{32'hEB123456, 4'd10, 4'd10}, // R4 branch link
    '{32'h0A0FFF0F, 4'd10, 4'd10}, // R1 ignored bits set
    '{32'hE8BD0000, 4'd9,  4'd9 }, // R4 block
    '{32'hE6000010, 4'd8,  4'd8 }, // R4 undefined
    '{32'hE6000000, 4'd7,  4'd7 }, // R4 single (bit0 clear)
    '{32'hE5900000, 4'd7,  4'd7 }, // R4 single
    '{32'hE1D000B0, 4'd6,  4'd0 }, // R5 hw imm
    '{32'hE19000B0, 4'd5,  4'd0 }, // R5 hw reg
    '{32'hE12FFF10, 4'd4,  4'd4 }, // R5 bx
    '{32'hE1000090, 4'd5,  4'd3 }, // R2 swap shadowed
    '{32'hE0000090, 4'd5,  4'd1 }, // R2 mul shadowed
    '{32'hE0800090, 4'd5,  4'd2 }, // R2 mull shadowed
    '{32'hE0C00090, 4'd6,  4'd2 }, // R2 mull shadowed by imm
    '{32'hE3A00001, 4'd0,  4'd0 }, // R6 dp imm
    '{32'hE0810002, 4'd0,  4'd0 }, // R6 dp reg
    '{32'hE0000010, 4'd0,  4'd0 }, // R6 dp bit3 clear
    '{32'hE10F0000, 4'd0,  4'd0 }, // R6 status
    '{32'hFF000000, 4'd14, 4'd15}, // R7 unknown in part
    '{32'h1EFFF0FF, 4'd13, 4'd13}  // R1 ignored bits set
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic        out_ready = 1'b1;
  logic        rdy_a, rdy_b, ov_a, ov_b, unk_a, unk_b;
  logic [3:0]  cls_a, cls_b;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_class_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a),
    .in_instr(in_instr), .out_valid(ov_a), .out_ready(out_ready),
    .out_class(cls_a), .out_unknown(unk_a)
  );

  instr_class_decoder #(.ENTRY_EN(PART_EN)) dut_part_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_b),
    .in_instr(in_instr), .out_valid(ov_b), .out_ready(out_ready),
    .out_class(cls_b), .out_unknown(unk_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input logic [3:0] ea, input logic [3:0] eb);
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = w;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 valid", {31'd0, ov_a}, 32'd1);
    chk("R3-6 class", {28'd0, cls_a}, {28'd0, ea});
    chk("R7 flag", {31'd0, unk_a}, {31'd0, ea == 4'd15});
    chk("R2/R7 part class", {28'd0, cls_b}, {28'd0, eb});
    chk("R7 part flag", {31'd0, unk_b}, {31'd0, eb == 4'd15});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 out_valid", {31'd0, ov_a}, 32'd0);
    chk("R10 in_ready", {31'd0, rdy_a}, 32'd1);

    for (int i = 0; i < NV; i++) send(VECS[i].instr, VECS[i].exp_full, VECS[i].exp_part);

    @(negedge clk);
    chk("R8 drained", {31'd0, ov_a}, 32'd0);

    // R9 back-pressure
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_instr = 32'hEA000000;
    @(negedge clk);
    in_instr = 32'hE5900000;
    chk("R9 stall ready", {31'd0, rdy_a}, 32'd0);
    chk("R9 held class", {28'd0, cls_a}, 32'd10);
    repeat (3) @(negedge clk);
    chk("R9 still ready low", {31'd0, rdy_a}, 32'd0);
    chk("R9 still held", {28'd0, cls_a}, 32'd10);
    chk("R9 still valid", {31'd0, ov_a}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 next class", {28'd0, cls_a}, 32'd7);
    chk("R8 next valid", {31'd0, ov_a}, 32'd1);
    @(negedge clk);
    chk("R8 empty after drain", {31'd0, ov_a}, 32'd0);

    // R10 mid-run reset
    in_valid = 1'b1;
    in_instr = 32'hEF000000;
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R10 reset clears", {31'd0, ov_a}, 32'd0);
    chk("R10 ready after reset", {31'd0, rdy_a}, 32'd1);
    out_ready = 1'b1;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule